// File: doc/BRIEF.md
# Reset-Time Serial EEPROM Configuration Loader

After reset this block reads configuration defaults out of a serial EEPROM with a two-wire interface. It drives the bus clock and data lines itself, as open-drain pull-downs. It fetches the EEPROM in four-byte bursts. Each burst sets the EEPROM's internal pointer with a dummy write of the word address, then makes a repeated start and reads four sequential bytes. The byte at EEPROM offset 00h decides whether anything is loaded. Every later offset is steered through a small lookup to one of nine target registers. Each offset writes only the bit positions that its mask allows, and a few bits are moved to a different position on the way.

The loaded registers are kept inside the block and presented on one flat output vector, with register k in bits `[32k+31:32k]`. The surrounding logic owns what these registers mean. From reset until loading ends, `host_hold` tells that logic to hold off host register access. The end of loading is marked by a one-cycle `load_done`, whether the load completed, was skipped or failed. A missing acknowledge from the EEPROM sets `load_error` and puts every register back to zero.

The controller moves through named states:
- **IDLE** goes to START when `bus_present` is high, and to FINISH when it is low.
- **START** goes to DEV_WR.
- **DEV_WR** goes to WORD on an acknowledge, and to STOP on a missing one.
- **WORD** goes to RESTART on an acknowledge, and to STOP on a missing one.
- **RESTART** goes to DEV_RD.
- **DEV_RD** goes to READ on an acknowledge, and to STOP on a missing one.
- **READ** repeats itself for four bytes, then goes to STOP.
- **STOP** goes back to START for the next burst. It goes to FINISH instead after an error, after the last burst, or when the flag byte does not request loading.
- **FINISH** lasts one cycle and goes to HALT.
- **HALT** is the final state and never changes.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: Loading starts by itself when reset is released, with no trigger input. If `bus_present` is low at that time, the block finishes without ever pulling either bus line low and without a bus transaction.
- R2: Each burst has this sequence:
  - a start condition;
  - device address 1010000b followed by a 0 (write), then the slave acknowledge;
  - the word address, then the slave acknowledge;
  - a repeated start;
  - device address 1010000b followed by a 1 (read), then the slave acknowledge;
  - four data bytes, each followed by a master acknowledge (data low during the ninth clock);
  - a stop condition.

  The word addresses go 00h, 04h, 08h and so on up to 18h, which makes seven bursts when loading.
- R3: The byte at offset 00h is the load flag. Only the value 01h loads. FFh, or any other value, ends loading after the first burst with every register at zero and no error.
- R4: Offset 01h goes to register 0. EEPROM bits 6–5 and 2–0 land in the same bit positions, EEPROM bit 7 lands in bit 8, and all other bits of the register stay zero.
- R5: Some offsets are full-byte copies:
  - offsets 02h–05h fill register 1 in byte lanes 0 to 3;
  - offsets 0Ah–0Dh fill register 3 in byte lanes 0 to 3;
  - offset 17h fills register 7 in byte lane 0.
- R6: Some offsets are masked:
  - offsets 06h–09h fill register 2 in lanes 0 to 3, but offset 06h writes only bits 7–1;
  - offsets 0Eh–11h fill register 4 in lanes 0 to 3, but offset 11h writes only bits 3–0;
  - offsets 12h–15h fill register 5 in lanes 0 to 3 under the byte masks C0h, 80h, 4Fh and 9Fh;
  - offsets 19h–1Bh are read but have no effect.
- R7: Offset 16h bit 7 goes to register 6 bit 15. Offset 18h bit 3 goes to register 8 bit 27. No other bits of these two registers change.
- R8: A missing slave acknowledge after either device address is handled the same way:
  - the current transfer is ended with a stop;
  - no further burst follows;
  - `load_error` is raised;
  - all nine registers are zero when loading finishes, even those written by earlier bursts.
- R9: `host_hold` is high from reset until `load_done`. `load_done` is high for exactly one cycle, `host_hold` goes low in that same cycle, and both stay low afterwards.
- R10: Once loading has finished, both bus lines are released and the register image does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_present | input | 1 | High when an EEPROM bus is fitted |
| sda_in | input | 1 | Level seen on the data line |
| scl_low | output | 1 | Pull the bus clock line low |
| sda_low | output | 1 | Pull the bus data line low |
| host_hold | output | 1 | Host register access must wait |
| load_done | output | 1 | One-cycle end-of-load pulse |
| load_error | output | 1 | Load aborted on a missing acknowledge |
| cfg_image | output | 288 | Nine 32-bit loaded registers, register k at bits [32k+31:32k] |

## Verification
The hardest case to reach is an acknowledge that goes missing in the middle of a load, after earlier bursts have already filled some registers. The bench's EEPROM model counts the device-address phases it sees and withholds its acknowledge at one chosen phase: the first write address, the read address of the third burst, or the write address of the last burst. That shows the rollback to zero, the stop, and the absence of any later burst at several depths. The skip paths use flag values of FFh and 5Ah over a non-zero memory. The mapping is swept over four memory patterns, including all-ones, so that every mask and relocated bit is exercised.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int NREG = 9;

    typedef enum logic [1:0] {
        BUS_START = 2'd0,
        BUS_STOP  = 2'd1,
        BUS_TX    = 2'd2,
        BUS_RX    = 2'd3
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_DEV_WR, S_WORD, S_RESTART,
        S_DEV_RD, S_READ, S_STOP, S_FINISH, S_HALT
    } load_state_e;

    typedef enum logic [3:0] {
        SEL_CMD     = 4'd0,
        SEL_SUBSYS  = 4'd1,
        SEL_LEGBASE = 4'd2,
        SEL_SYSCTL  = 4'd3,
        SEL_ROUTE   = 4'd4,
        SEL_MISC    = 4'd5,
        SEL_PMCAP   = 4'd6,
        SEL_CARDID  = 4'd7,
        SEL_SOCKEVT = 4'd8
    } reg_sel_e;

endpackage

// File: rtl/cfg_bus_engine.sv
// Symbol-level two-wire master: start, stop, byte out with ack sample,
// byte in with master ack. Each symbol is four quarters of QTR_CYCLES.
module cfg_bus_engine
    import cfg_loader_pkg::*;
#(
    parameter int QTR_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  bus_op_e    cmd_op,
    input  logic [7:0] cmd_byte,
    input  logic       sda_in,
    output logic       op_done,
    output logic       ack_missing,
    output logic [7:0] rx_byte,
    output logic       scl_low,
    output logic       sda_low
);
    localparam int TW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;

    logic          active;
    bus_op_e       op_q;
    logic [7:0]    shreg;
    logic [3:0]    sym;
    logic [1:0]    qtr;
    logic [TW-1:0] tick;
    logic          nack_q;
    logic          scl_lvl, sda_lvl, last_sym, qtr_end;

    assign qtr_end  = (tick == TW'(QTR_CYCLES - 1));
    assign last_sym = (op_q == BUS_START || op_q == BUS_STOP) ? (sym == 4'd0) : (sym == 4'd8);

    // Line levels for the current quarter; data changes only while clock is low
    always_comb begin
        scl_lvl = (qtr == 2'd1) || (qtr == 2'd2);
        sda_lvl = 1'b1;
        unique case (op_q)
            BUS_START: sda_lvl = (qtr < 2'd2);
            BUS_STOP: begin
                scl_lvl = (qtr != 2'd0);
                sda_lvl = (qtr >= 2'd2);
            end
            BUS_TX:    sda_lvl = (sym == 4'd8) ? 1'b1 : shreg[3'd7 - sym[2:0]];
            BUS_RX:    sda_lvl = (sym == 4'd8) ? 1'b0 : 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            op_q    <= BUS_START;
            shreg   <= '0;
            sym     <= '0;
            qtr     <= '0;
            tick    <= '0;
            nack_q  <= 1'b0;
            op_done <= 1'b0;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            op_done <= 1'b0;
            if (!active) begin
                if (cmd_valid) begin
                    active <= 1'b1;
                    op_q   <= cmd_op;
                    shreg  <= cmd_byte;
                    sym    <= '0;
                    qtr    <= '0;
                    tick   <= '0;
                    nack_q <= 1'b0;
                end
            end else begin
                scl_low <= !scl_lvl;
                sda_low <= !sda_lvl;
                if (qtr_end) begin
                    tick <= '0;
                    qtr  <= qtr + 2'd1;
                    if (qtr == 2'd2) begin
                        if (op_q == BUS_RX && sym != 4'd8) shreg <= {shreg[6:0], sda_in};
                        if (op_q == BUS_TX && sym == 4'd8) nack_q <= sda_in;
                    end
                    if (qtr == 2'd3) begin
                        if (last_sym) begin
                            active  <= 1'b0;
                            op_done <= 1'b1;
                        end else begin
                            sym <= sym + 4'd1;
                        end
                    end
                end else begin
                    tick <= tick + TW'(1);
                end
            end
        end
    end

    assign ack_missing = nack_q;
    assign rx_byte     = shreg;
endmodule

// File: rtl/cfg_byte_map.sv
// Offset lookup: which register, which lane, which bits, and bit relocations.
module cfg_byte_map
    import cfg_loader_pkg::*;
(
    input  logic [7:0]  offset,
    input  logic [7:0]  data_in,
    output logic        hit,
    output reg_sel_e    sel,
    output logic [31:0] wdata,
    output logic [31:0] wmask
);
    logic [1:0] lane;
    logic [7:0] bmask;
    logic       remap;

    always_comb begin
        hit   = 1'b1;
        sel   = SEL_CMD;
        lane  = 2'd0;
        bmask = 8'hFF;
        remap = 1'b0;
        if (offset == 8'h01) begin
            remap = 1'b1;
        end else if (offset >= 8'h02 && offset <= 8'h05) begin
            sel  = SEL_SUBSYS;
            lane = offset[1:0] - 2'd2;
        end else if (offset >= 8'h06 && offset <= 8'h09) begin
            sel   = SEL_LEGBASE;
            lane  = offset[1:0] - 2'd2;
            bmask = (offset == 8'h06) ? 8'hFE : 8'hFF;
        end else if (offset >= 8'h0A && offset <= 8'h0D) begin
            sel  = SEL_SYSCTL;
            lane = offset[1:0] - 2'd2;
        end else if (offset >= 8'h0E && offset <= 8'h11) begin
            sel   = SEL_ROUTE;
            lane  = offset[1:0] - 2'd2;
            bmask = (offset == 8'h11) ? 8'h0F : 8'hFF;
        end else if (offset >= 8'h12 && offset <= 8'h15) begin
            sel  = SEL_MISC;
            lane = offset[1:0] - 2'd2;
            unique case (lane)
                2'd0: bmask = 8'hC0;
                2'd1: bmask = 8'h80;
                2'd2: bmask = 8'h4F;
                2'd3: bmask = 8'h9F;
            endcase
        end else if (offset == 8'h16) begin
            sel   = SEL_PMCAP;
            lane  = 2'd1;
            bmask = 8'h80;
        end else if (offset == 8'h17) begin
            sel = SEL_CARDID;
        end else if (offset == 8'h18) begin
            sel   = SEL_SOCKEVT;
            lane  = 2'd3;
            bmask = 8'h08;
        end else begin
            hit = 1'b0;
        end
    end

    always_comb begin
        if (remap) begin
            wdata = {23'd0, data_in[7], 1'b0, data_in[6:0]};
            wmask = 32'h0000_0167;
        end else begin
            wdata = {4{data_in}};
            wmask = {24'd0, bmask} << {lane, 3'b000};
        end
    end
endmodule

// File: rtl/cfg_reg_image.sv
// Loaded register image with masked byte merge and a clear for aborts.
module cfg_reg_image
    import cfg_loader_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [31:0]      wr_mask,
    output logic [NREG*32-1:0] image
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [31:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r <= '0;
            end else if (clear) begin
                r <= '0;
            end else if (wr_en && wr_sel == reg_sel_e'(i)) begin
                r <= (r & ~wr_mask) | (wr_data & wr_mask);
            end
        end
        assign image[32*i +: 32] = r;
    end
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
    import cfg_loader_pkg::*;
#(
    parameter int         QTR_CYCLES  = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter logic [7:0] LAST_OFFSET = 8'h18,
    parameter logic [7:0] FLAG_LOAD   = 8'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_present,
    input  logic               sda_in,
    output logic               scl_low,
    output logic               sda_low,
    output logic               host_hold,
    output logic               load_done,
    output logic               load_error,
    output logic [NREG*32-1:0] cfg_image
);
    localparam logic [7:0] LAST_BASE = LAST_OFFSET & 8'hFC;

    load_state_e state, next;
    logic        issue;
    logic [7:0]  base;
    logic [1:0]  idx;
    logic        flag_ok;
    logic        fail;

    bus_op_e     cmd_op;
    logic [7:0]  cmd_byte;
    logic        op_done, ack_missing;
    logic [7:0]  rx_byte;
    logic [7:0]  offset;
    logic        map_hit, wr_en, clear, tx_state, bus_state;
    reg_sel_e    map_sel;
    logic [31:0] map_data, map_mask;

    assign tx_state  = (state == S_DEV_WR) || (state == S_WORD) || (state == S_DEV_RD);
    assign offset    = base + {6'd0, idx};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next;
    end

    // Transitions
    always_comb begin
        next = state;
        unique case (state)
            S_IDLE:    next = bus_present ? S_START : S_FINISH;
            S_START:   if (op_done) next = S_DEV_WR;
            S_DEV_WR:  if (op_done) next = ack_missing ? S_STOP : S_WORD;
            S_WORD:    if (op_done) next = ack_missing ? S_STOP : S_RESTART;
            S_RESTART: if (op_done) next = S_DEV_RD;
            S_DEV_RD:  if (op_done) next = ack_missing ? S_STOP : S_READ;
            S_READ:    if (op_done && idx == 2'd3) next = S_STOP;
            S_STOP:    if (op_done) next = (fail || !flag_ok || base == LAST_BASE) ? S_FINISH : S_START;
            S_FINISH:  next = S_HALT;
            S_HALT:    next = S_HALT;
            default:   next = S_HALT;
        endcase
    end

    always_comb begin
        bus_state = 1'b1;
        unique case (next)
            S_IDLE, S_FINISH, S_HALT: bus_state = 1'b0;
            default:                  bus_state = 1'b1;
        endcase
    end

    // Registered outputs and burst bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue   <= 1'b0;
            base    <= '0;
            idx     <= '0;
            flag_ok <= 1'b0;
            fail    <= 1'b0;
        end else begin
            issue <= bus_state && ((next != state) || op_done);
            if (tx_state && op_done && ack_missing) fail <= 1'b1;
            if (state == S_READ && op_done) begin
                idx <= idx + 2'd1;
                if (base == 8'd0 && idx == 2'd0) flag_ok <= (rx_byte == FLAG_LOAD);
            end
            if (state == S_STOP && next == S_START) base <= base + 8'd4;
        end
    end

    // Command for the current state
    always_comb begin
        cmd_op   = BUS_START;
        cmd_byte = 8'h00;
        unique case (state)
            S_DEV_WR: begin cmd_op = BUS_TX; cmd_byte = {DEV_ADDR, 1'b0}; end
            S_WORD:   begin cmd_op = BUS_TX; cmd_byte = base;             end
            S_DEV_RD: begin cmd_op = BUS_TX; cmd_byte = {DEV_ADDR, 1'b1}; end
            S_READ:   cmd_op = BUS_RX;
            S_STOP:   cmd_op = BUS_STOP;
            default:  cmd_op = BUS_START;
        endcase
    end

    assign wr_en = (state == S_READ) && op_done && map_hit && (offset != 8'd0) && flag_ok;
    assign clear = tx_state && op_done && ack_missing;

    assign host_hold  = (state != S_FINISH) && (state != S_HALT);
    assign load_done  = (state == S_FINISH);
    assign load_error = fail;

    cfg_bus_engine #(.QTR_CYCLES(QTR_CYCLES)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (issue),
        .cmd_op      (cmd_op),
        .cmd_byte    (cmd_byte),
        .sda_in      (sda_in),
        .op_done     (op_done),
        .ack_missing (ack_missing),
        .rx_byte     (rx_byte),
        .scl_low     (scl_low),
        .sda_low     (sda_low)
    );

    cfg_byte_map u_map (
        .offset  (offset),
        .data_in (rx_byte),
        .hit     (map_hit),
        .sel     (map_sel),
        .wdata   (map_data),
        .wmask   (map_mask)
    );

    cfg_reg_image u_image (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .wr_en   (wr_en),
        .wr_sel  (map_sel),
        .wr_data (map_data),
        .wr_mask (map_mask),
        .image   (cfg_image)
    );
endmodule

// File: rtl/cfg_eeprom_loader_chk.sv
module cfg_eeprom_loader_chk
    import cfg_loader_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               host_hold,
    input logic               load_done,
    input logic               load_error,
    input logic               scl_low,
    input logic               sda_low,
    input logic [NREG*32-1:0] cfg_image
);
    p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);

    p_done_drops_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !host_hold);

    p_hold_falls_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_hold) |-> load_done);

    p_hold_stays_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_hold |=> !host_hold);

    p_bus_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_hold |-> (!scl_low && !sda_low));

    p_image_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_hold |=> $stable(cfg_image));

    p_error_image_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_error |-> (cfg_image == '0));
endmodule

bind cfg_eeprom_loader cfg_eeprom_loader_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_hold  (host_hold),
    .load_done  (load_done),
    .load_error (load_error),
    .scl_low    (scl_low),
    .sda_low    (sda_low),
    .cfg_image  (cfg_image)
);

// File: tb/cfg_eeprom_loader_test.sv
`timescale 1ns/1ps
module cfg_eeprom_loader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic present_r = 1'b1;
    logic scl_low, sda_low, host_hold, load_done, load_error;
    logic [9*32-1:0] cfg_image;
    logic pull = 1'b0;
    logic sda_bus;

    always #2 clk = ~clk;

    assign sda_bus = !(sda_low || pull);

    cfg_eeprom_loader uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_present (present_r),
        .sda_in      (sda_bus),
        .scl_low     (scl_low),
        .sda_low     (sda_low),
        .host_hold   (host_hold),
        .load_done   (load_done),
        .load_error  (load_error),
        .cfg_image   (cfg_image)
    );

    int checks = 0;
    int failures = 0;
    logic [7:0] mem [0:31];

    // ---------------- EEPROM model (sampled away from the active edge) ----
    localparam int M_IDLE = 0, M_ADDR = 1, M_WORD = 2, M_SEND = 3;
    int mode, bitn, aphase, rd_cnt, mack_cnt, word_err, sent, nack_at;
    logic [7:0] sh, ptr, word_expect;
    logic rw, prev_scl, prev_sda;

    always @(negedge clk) begin
        logic scl_v, sda_v;
        scl_v = !scl_low;
        sda_v = !(sda_low || pull);
        if (!rst_n) begin
            mode = M_IDLE; bitn = 0; aphase = 0; rd_cnt = 0; mack_cnt = 0;
            word_err = 0; sent = 0; pull = 1'b0; word_expect = 8'h00;
            ptr = 8'h00; sh = 8'h00; rw = 1'b0;
        end else if (prev_scl && scl_v && prev_sda && !sda_v) begin
            mode = M_ADDR; bitn = 0; pull = 1'b0;
        end else if (prev_scl && scl_v && !prev_sda && sda_v) begin
            mode = M_IDLE; pull = 1'b0;
        end else if (!prev_scl && scl_v) begin
            if (mode == M_ADDR || mode == M_WORD) begin
                if (bitn < 8) sh = {sh[6:0], sda_v};
                bitn++;
            end else if (mode == M_SEND) begin
                if (bitn == 8 && !sda_v) mack_cnt++;
                bitn++;
            end
        end else if (prev_scl && !scl_v) begin
            if (mode == M_ADDR || mode == M_WORD) begin
                if (bitn == 8) begin
                    if (mode == M_ADDR) begin
                        if (sh[7:1] == 7'h50 && aphase != nack_at) begin
                            pull = 1'b1; rw = sh[0];
                            if (sh[0]) rd_cnt++;
                        end else begin
                            mode = M_IDLE;
                        end
                        aphase++;
                    end else begin
                        ptr = sh;
                        if (sh != word_expect) word_err++;
                        word_expect = word_expect + 8'd4;
                        pull = 1'b1;
                    end
                end else if (bitn == 9) begin
                    pull = 1'b0; bitn = 0;
                    if (mode == M_WORD) mode = M_IDLE;
                    else if (rw) begin
                        mode = M_SEND; sent = 0; sh = mem[ptr[4:0]]; pull = !sh[7];
                    end else mode = M_WORD;
                end
            end else if (mode == M_SEND) begin
                if (bitn < 8) pull = !sh[3'(7 - bitn)];
                else if (bitn == 8) pull = 1'b0;
                else begin
                    ptr = ptr + 8'd1; sent++; bitn = 0;
                    // model device stops driving after a four-byte burst
                    if (sent < 4) begin sh = mem[ptr[4:0]]; pull = !sh[7]; end
                    else begin mode = M_IDLE; pull = 1'b0; end
                end
            end
        end
        prev_scl = scl_v;
        prev_sda = !(sda_low || pull);
    end

    // ---------------- expected values from the requirements -------------
    function automatic logic [31:0] exp_reg(int r);
        case (r)
            0: return {23'd0, mem[1][7], 1'b0, mem[1][6:5], 2'd0, mem[1][2:0]};
            1: return {mem[5], mem[4], mem[3], mem[2]};
            2: return {mem[9], mem[8], mem[7], mem[6] & 8'hFE};
            3: return {mem[13], mem[12], mem[11], mem[10]};
            4: return {4'd0, mem[17][3:0], mem[16], mem[15], mem[14]};
            5: return {mem[21] & 8'h9F, mem[20] & 8'h4F, mem[19] & 8'h80, mem[18] & 8'hC0};
            6: return {16'd0, mem[22][7], 15'd0};
            7: return {24'd0, mem[23]};
            default: return {4'd0, mem[24][3], 27'd0};
        endcase
    endfunction

    function automatic string reg_req(int r);
        case (r)
            0: return "R4";
            1, 3, 7: return "R5";
            2, 4, 5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] flag, input int pat);
        for (int i = 0; i < 32; i++) begin
            case (pat)
                0: mem[i] = 8'hFF;
                1: mem[i] = 8'(i * 37 + 11);
                2: mem[i] = (i[0] ? 8'hA5 : 8'h5A) ^ 8'(i);
                default: mem[i] = ~8'(i * 53);
            endcase
        end
        mem[0] = flag;
    endtask

    task automatic run_load(input string tag, input logic present, input int nack_phase,
                            input logic expect_load, input logic expect_err,
                            input int expect_reads);
        logic got;
        logic [9*32-1:0] snap;
        present_r = present;
        nack_at   = nack_phase;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", "hold in reset", 32'(host_hold), 32'd1);
        chk("R9", "done in reset", 32'(load_done), 32'd0);
        chk("R8", "error in reset", 32'(load_error), 32'd0);
        chk("R10", "image in reset", 32'(cfg_image != '0), 32'd0);
        rst_n = 1'b1;
        got = 1'b0;
        for (int c = 0; c < 20000 && !got; c++) begin
            @(negedge clk);
            if (load_done) got = 1'b1;
        end
        chk("R9", {tag, " done seen"}, 32'(got), 32'd1);
        chk("R9", {tag, " hold low at done"}, 32'(host_hold), 32'd0);
        chk("R8", {tag, " error flag"}, 32'(load_error), 32'(expect_err));
        chk(expect_load ? "R2" : tag, "read bursts", 32'(rd_cnt), 32'(expect_reads));
        chk("R2", "master acks", 32'(mack_cnt), 32'(4 * expect_reads));
        chk("R2", "word address order", 32'(word_err), 32'd0);
        if (!present) chk("R1", "address phases", 32'(aphase), 32'd0);
        for (int r = 0; r < 9; r++)
            chk(expect_load ? reg_req(r) : tag, $sformatf("%s reg%0d", tag, r),
                cfg_image[32*r +: 32], expect_load ? exp_reg(r) : 32'd0);
        snap = cfg_image;
        @(negedge clk);
        chk("R9", "done one cycle", 32'(load_done), 32'd0);
        repeat (20) @(negedge clk);
        chk("R10", "bus released", 32'({scl_low, sda_low}), 32'd0);
        chk("R10", "image stable", 32'(cfg_image != snap), 32'd0);
        chk("R9", "hold stays low", 32'(host_hold), 32'd0);
    endtask

    initial begin
        fill(8'h01, 1);
        run_load("R1", 1'b0, -1, 1'b0, 1'b0, 0);
        fill(8'hFF, 1);
        run_load("R3", 1'b1, -1, 1'b0, 1'b0, 1);
        fill(8'h5A, 2);
        run_load("R3", 1'b1, -1, 1'b0, 1'b0, 1);
        for (int p = 0; p < 4; p++) begin
            fill(8'h01, p);
            run_load("R2", 1'b1, -1, 1'b1, 1'b0, 7);
        end
        fill(8'h01, 0);
        run_load("R8", 1'b1, 0, 1'b0, 1'b1, 0);
        run_load("R8", 1'b1, 5, 1'b0, 1'b1, 2);
        run_load("R8", 1'b1, 12, 1'b0, 1'b1, 6);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule